// File: doc/BRIEF.md
# Line-buffered 2D lifting wavelet transform

This block computes one level of a separable two-dimensional integer wavelet transform on a square tile of N×N signed pixels, with N = 8 and 16-bit pixels by default. Pixels enter in raster order on a valid/ready stream. As each row completes, one shared lifting datapath splits the row into even and odd samples and applies predict, update and scale steps. The row result goes into an internal tile buffer. When the last row has been stored, the same datapath filters the buffer column by column, one column per cycle, and writes the results back in place.

The transformed tile then leaves on a second valid/ready stream in raster order. Each coefficient carries a two-bit subband code. The low-pass half of each dimension occupies indices 0..N/2-1 and the high-pass half occupies N/2..N-1. A one-cycle done pulse follows the acceptance of the final coefficient, which is always in the high/high subband. The input is stalled from the last pixel of a tile until the output of that tile is complete. The next tile can start on the cycle after done.

Top module: `dwt2d_lift`

## Requirements
- R1: `in_ready_o` is high while a tile is being loaded. It is low from the cycle after the last pixel of a tile is accepted until the last output coefficient of that tile is accepted.
- R2: Output coefficients leave in raster order over the N×N result. `out_band_o` = {row ≥ N/2, column ≥ N/2}: 0 is low/low (top-left), 1 is horizontal high (top-right), 2 is vertical high (bottom-left) and 3 is high/high (bottom-right). The first coefficient of a tile carries code 0.
- R3: Predict: with e[i] = x[2i] and o[i] = x[2i+1], d[i] = o[i] − floor((e[i] + e[i+1]) / 2). At the right edge, e[i] stands in for the missing e[i+1].
- R4: Update: s[i] = e[i] + floor((d[i−1] + d[i] + 2) / 4). At the left edge, d[0] stands in for the missing d[−1]. In each 1D result, s occupies indices 0..N/2−1 and d occupies N/2..N−1.
- R5: Every row is lifted first. Every column of the row results is then lifted with the same 1D step, and the output is the tile after both passes.
- R6: With K_Q = INV_K_Q = 16384 (1.0 in Q2.14), scaling is bypassed and the output equals the pure integer lifting result bit for bit.
- R7: Otherwise, after each 1D pass the low outputs become floor(s·INV_K_Q / 2^14) and the high outputs become floor(d·K_Q / 2^14). Results are kept in DW+3 bit two's complement.
- R8: `done_o` is high for exactly one cycle, on the cycle after the last coefficient (band 3) is accepted.
- R9: While `out_valid_o` is high and `out_ready_i` is low, valid, data and band hold their values.
- R10: A tile loaded right after done is transformed independently of the previous tile.
- R11: After reset, `in_ready_o` is 1, `out_valid_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Pixel valid |
| in_ready_o | output | 1 | Pixel ready |
| in_data_i | input | DW | Signed pixel, raster order |
| out_valid_o | output | 1 | Coefficient valid |
| out_ready_i | input | 1 | Coefficient ready |
| out_data_o | output | DW+3 | Signed coefficient |
| out_band_o | output | 2 | Subband code {row high, column high} |
| done_o | output | 1 | One-cycle pulse after the last coefficient |

## Verification
The bench goes after the tile edges, where each 1D pass reuses a neighbour: an impulse in a corner pixel and ramps expose a wrong extension as a wrong coefficient in the first or last low/high column. Full-scale constant and checkerboard tiles drive the largest growth through both passes, where a datapath that is too narrow would wrap sign. A second instance with k ≠ 1 checks the floor rounding of the scaled path. Random backpressure checks that held output is stable, that the done pulse lands on the right cycle, and that input stays stalled until the tile drains; a misordered scan would emit wrong band codes.

// File: rtl/dwt2d_pkg.sv
package dwt2d_pkg;
  localparam int Q_FRAC = 14;
  localparam int Q_ONE  = 1 << Q_FRAC;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_VERT = 2'd1,
    PH_OUT  = 2'd2
  } phase_e;
endpackage

// File: rtl/dwt2d_lift_1d.sv
module dwt2d_lift_1d
  import dwt2d_pkg::*;
#(
  parameter int N       = 8,
  parameter int CW      = 19,
  parameter int K_Q     = Q_ONE,
  parameter int INV_K_Q = Q_ONE
) (
  input  logic [N*CW-1:0] x_i,
  output logic [N*CW-1:0] y_o
);
  localparam int M  = N / 2;
  localparam int AW = CW + 2;
  localparam logic signed [AW-1:0] RND = AW'(2);

  logic signed [AW-1:0] ev [M];
  logic signed [AW-1:0] od [M];
  logic signed [AW-1:0] dd [M];
  logic signed [AW-1:0] ss [M];
  logic signed [CW-1:0] lo [M];
  logic signed [CW-1:0] hi [M];

  always_comb begin
    for (int i = 0; i < M; i++) begin
      ev[i] = AW'($signed(x_i[(2*i)*CW +: CW]));
      od[i] = AW'($signed(x_i[(2*i+1)*CW +: CW]));
    end
    for (int i = 0; i < M; i++) begin
      int j;
      j = (i == M-1) ? i : i + 1;   // right-edge symmetric extension
      dd[i] = od[i] - ((ev[i] + ev[j]) >>> 1);
    end
    for (int i = 0; i < M; i++) begin
      int k;
      k = (i == 0) ? 0 : i - 1;     // left-edge symmetric extension
      ss[i] = ev[i] + ((dd[k] + dd[i] + RND) >>> 2);
    end
    for (int i = 0; i < M; i++) begin
      lo[i] = CW'(ss[i]);
      hi[i] = CW'(dd[i]);
    end
  end

  function automatic logic signed [CW-1:0] scale_q(input logic signed [CW-1:0] v, input int q);
    logic signed [CW+17:0] vv, qq, pp;
    vv = (CW+18)'(v);
    qq = (CW+18)'(q);
    pp = vv * qq;
    return CW'(pp >>> Q_FRAC);
  endfunction

  generate
    if (K_Q == Q_ONE && INV_K_Q == Q_ONE) begin : g_bypass
      always_comb begin
        for (int i = 0; i < M; i++) begin
          y_o[i*CW +: CW]     = lo[i];
          y_o[(M+i)*CW +: CW] = hi[i];
        end
      end
    end else begin : g_scale
      always_comb begin
        for (int i = 0; i < M; i++) begin
          y_o[i*CW +: CW]     = scale_q(lo[i], INV_K_Q);
          y_o[(M+i)*CW +: CW] = scale_q(hi[i], K_Q);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dwt2d_tile_buf.sv
module dwt2d_tile_buf #(
  parameter int N  = 8,
  parameter int CW = 19,
  parameter int IW = 3
) (
  input  logic            clk_i,
  input  logic            row_we_i,
  input  logic [IW-1:0]   row_sel_i,
  input  logic [N*CW-1:0] row_wdata_i,
  input  logic            col_we_i,
  input  logic [IW-1:0]   col_sel_i,
  input  logic [N*CW-1:0] col_wdata_i,
  output logic [N*CW-1:0] col_rdata_o,
  input  logic [IW-1:0]   rd_row_i,
  input  logic [IW-1:0]   rd_col_i,
  output logic [CW-1:0]   pix_o
);
  logic [CW-1:0] mem [N][N];

  always_ff @(posedge clk_i) begin
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        if (row_we_i && row_sel_i == IW'(r))
          mem[r][c] <= row_wdata_i[c*CW +: CW];
        else if (col_we_i && col_sel_i == IW'(c))
          mem[r][c] <= col_wdata_i[r*CW +: CW];
      end
    end
  end

  always_comb begin
    for (int r = 0; r < N; r++) col_rdata_o[r*CW +: CW] = mem[r][col_sel_i];
  end

  assign pix_o = mem[rd_row_i][rd_col_i];
endmodule

// File: rtl/dwt2d_lift.sv
module dwt2d_lift
  import dwt2d_pkg::*;
#(
  parameter int DW      = 16,
  parameter int N       = 8,
  parameter int K_Q     = Q_ONE,
  parameter int INV_K_Q = Q_ONE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [DW-1:0]      in_data_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [DW+2:0]      out_data_o,
  output logic [1:0]         out_band_o,
  output logic               done_o
);
  localparam int CW = DW + 3;
  localparam int M  = N / 2;
  localparam int IW = (N > 2) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);
  localparam logic [IW-1:0] HALF = IW'(M);

  phase_e        phase_q;
  logic [IW-1:0] row_q, col_q;
  logic          done_q;
  logic [CW-1:0] row_sr [N-1];

  logic [N*CW-1:0] row_vec, col_vec, lift_x, lift_y;
  logic [CW-1:0]   pix;
  logic            in_fire, out_fire, row_end, tile_end;

  assign in_ready_o  = (phase_q == PH_LOAD);
  assign out_valid_o = (phase_q == PH_OUT);
  assign in_fire     = in_valid_i && in_ready_o;
  assign out_fire    = out_valid_o && out_ready_i;
  assign row_end     = in_fire && (col_q == LAST);
  assign tile_end    = out_fire && (row_q == LAST) && (col_q == LAST);

  always_comb begin
    for (int j = 0; j < N-1; j++) row_vec[j*CW +: CW] = row_sr[j];
    row_vec[(N-1)*CW +: CW] = CW'($signed(in_data_i));
  end

  // one datapath: rows while loading, columns during the vertical phase
  assign lift_x = (phase_q == PH_LOAD) ? row_vec : col_vec;

  dwt2d_lift_1d #(.N(N), .CW(CW), .K_Q(K_Q), .INV_K_Q(INV_K_Q)) u_lift (
    .x_i (lift_x),
    .y_o (lift_y)
  );

  dwt2d_tile_buf #(.N(N), .CW(CW), .IW(IW)) u_buf (
    .clk_i       (clk_i),
    .row_we_i    (row_end),
    .row_sel_i   (row_q),
    .row_wdata_i (lift_y),
    .col_we_i    (phase_q == PH_VERT),
    .col_sel_i   (col_q),
    .col_wdata_i (lift_y),
    .col_rdata_o (col_vec),
    .rd_row_i    (row_q),
    .rd_col_i    (col_q),
    .pix_o       (pix)
  );

  always_ff @(posedge clk_i) begin
    if (in_fire) begin
      for (int j = 0; j < N-2; j++) row_sr[j] <= row_sr[j+1];
      row_sr[N-2] <= CW'($signed(in_data_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_LOAD;
      row_q   <= '0;
      col_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= tile_end;
      unique case (phase_q)
        PH_LOAD: if (in_fire) begin
          col_q <= (col_q == LAST) ? '0 : col_q + 1'b1;
          if (row_end) begin
            row_q <= (row_q == LAST) ? '0 : row_q + 1'b1;
            if (row_q == LAST) phase_q <= PH_VERT;
          end
        end
        PH_VERT: begin
          col_q <= (col_q == LAST) ? '0 : col_q + 1'b1;
          if (col_q == LAST) phase_q <= PH_OUT;
        end
        PH_OUT: if (out_fire) begin
          col_q <= (col_q == LAST) ? '0 : col_q + 1'b1;
          if (col_q == LAST) row_q <= (row_q == LAST) ? '0 : row_q + 1'b1;
          if (tile_end) phase_q <= PH_LOAD;
        end
        default: phase_q <= PH_LOAD;
      endcase
    end
  end

  assign out_data_o = pix;
  assign out_band_o = {row_q >= HALF, col_q >= HALF};
  assign done_o     = done_q;

  AST_READY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R1
  AST_FIRST_LL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_band_o == 2'b00); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(out_band_o))); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_AFTER_HH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(out_valid_o && out_ready_i && out_band_o == 2'b11)); // R8
endmodule

// File: tb/dwt2d_lift_bench.sv
module dwt2d_lift_bench;
  localparam int N  = 8;
  localparam int M  = N / 2;
  localparam int DW = 16;
  localparam int CW = DW + 3;
  localparam int KS = 20000;
  localparam int IS = 13422;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_ready = 1'b0;
  logic in_ready_a, in_ready_b, out_valid_a, out_valid_b, done_a, done_b;
  logic [CW-1:0] out_data_a, out_data_b;
  logic [1:0] band_a, band_b;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  int tile_in [N][N];
  int w [N][N];
  int exp_a [N][N];
  int exp_b [N][N];

  always #2 clk = ~clk;

  dwt2d_lift #(.DW(DW), .N(N)) u_dwt2d_lift (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready_a),
    .in_data_i(in_data), .out_valid_o(out_valid_a), .out_ready_i(out_ready),
    .out_data_o(out_data_a), .out_band_o(band_a), .done_o(done_a));

  dwt2d_lift #(.DW(DW), .N(N), .K_Q(KS), .INV_K_Q(IS)) u_dwt2d_lift_scaled (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready_b),
    .in_data_i(in_data), .out_valid_o(out_valid_b), .out_ready_i(out_ready),
    .out_data_o(out_data_b), .out_band_o(band_b), .done_o(done_b));

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int scl(input int x, input int q);
    longint p;
    p = longint'(x) * longint'(q);
    return int'(p >>> 14);
  endfunction

  function automatic void lift_line(inout int v [N], input int kq, input int iq);
    int e [M]; int o [M]; int d [M]; int s [M];
    for (int i = 0; i < M; i++) begin e[i] = v[2*i]; o[i] = v[2*i+1]; end
    for (int i = 0; i < M; i++) d[i] = o[i] - ((e[i] + e[(i == M-1) ? i : i+1]) >>> 1);
    for (int i = 0; i < M; i++) s[i] = e[i] + ((d[(i == 0) ? 0 : i-1] + d[i] + 2) >>> 2);
    for (int i = 0; i < M; i++) begin v[i] = scl(s[i], iq); v[M+i] = scl(d[i], kq); end
  endfunction

  function automatic void model(input int kq, input int iq);
    int v [N];
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) v[c] = tile_in[r][c];
      lift_line(v, kq, iq);
      for (int c = 0; c < N; c++) w[r][c] = v[c];
    end
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < N; r++) v[r] = w[r][c];
      lift_line(v, kq, iq);
      for (int r = 0; r < N; r++) w[r][c] = v[r];
    end
  endfunction

  task automatic run_tile(input string tag);
    int idx;
    bit held;
    int h_data, h_band;
    model(16384, 16384);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) exp_a[r][c] = w[r][c];
    model(KS, IS);
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) exp_b[r][c] = w[r][c];
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        bit acc;
        acc = 1'b0;
        while (!acc) begin
          @(negedge clk);
          in_valid = ($urandom % 4) != 0;
          in_data  = DW'(tile_in[r][c]);
          if (in_valid) check({tag, "/R1 ready while loading"}, int'(in_ready_a), 1);
          acc = in_valid && in_ready_a;
          @(posedge clk);
        end
      end
    end
    idx = 0; held = 1'b0; h_data = 0; h_band = 0;
    while (idx < N*N) begin
      @(negedge clk);
      in_valid = 1'b0;
      check("R1 stalled", int'(in_ready_a), 0);
      if (held) begin
        check("R9 valid held", int'(out_valid_a), 1);
        check("R9 data held", int'($signed(out_data_a)), h_data);
        check("R9 band held", int'(band_a), h_band);
      end
      out_ready = ($urandom % 3) != 0;
      held = 1'b0;
      if (out_valid_a) begin
        int r, c;
        r = idx / N; c = idx % N;
        check({tag, " coefficient"}, int'($signed(out_data_a)), exp_a[r][c]);
        check("R7 scaled coefficient", int'($signed(out_data_b)), exp_b[r][c]);
        check("R2 band", int'(band_a), ((r >= M) ? 2 : 0) + ((c >= M) ? 1 : 0));
        check("R8 no early done", int'(done_a), 0);
        if (out_ready) idx++;
        else begin held = 1'b1; h_data = int'($signed(out_data_a)); h_band = int'(band_a); end
      end
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 done pulse", int'(done_a), 1);
    check("R10 ready after tile", int'(in_ready_a), 1);
    @(negedge clk);
    check("R8 done single cycle", int'(done_a), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    #1;
    check("R11 reset ready", int'(in_ready_a), 1);
    check("R11 reset valid", int'(out_valid_a), 0);
    check("R11 reset done", int'(done_a), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) tile_in[r][c] = (r == 0 && c == 0) ? 1000 : ((r == N-1 && c == N-1) ? -777 : 0);
    run_tile("R3 corner impulses");
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) tile_in[r][c] = 37 * c - 11 * r * r + 5;
    run_tile("R4 ramp edges");
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) tile_in[r][c] = 32767;
    run_tile("R6 full positive");
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) tile_in[r][c] = -32768;
    run_tile("R6 full negative");
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) tile_in[r][c] = ((r + c) % 2 == 0) ? 32767 : -32768;
    run_tile("R5 checkerboard");
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) tile_in[r][c] = (r % 2 == 0) ? -32768 : 32767;
    run_tile("R10 row stripes");
    for (int t = 0; t < 24; t++) begin
      for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) tile_in[r][c] = int'($signed(16'($urandom)));
      run_tile("R5 random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule